// File: doc/BRIEF.md
# Multi-channel output code clear controller

This block keeps the live 16-bit output code of four converter channels and lets a single external clear line force selected channels to a preset value. Software programs each channel through one register write port: a channel number, a register selector and a 16-bit data word. Per channel there are three registers: the live output code, a clear code, and a control word whose bit 0 arms that channel for clearing.

The clear line is asynchronous and active high. It passes through a two-stage synchroniser, and only its rising edge acts. On that edge every armed channel copies its clear code into its output code. Channels that are not armed are left alone. A cleared channel keeps the clear code after the line drops. It changes again only when software writes a new output code. If a write to the output code lands in the same cycle as the clear edge, the clear wins.

Top module: `out_clear_ctrl`

## Requirements
- R1: Only a rising edge of `clr_in` clears. Holding `clr_in` high produces exactly one clear, and an output code written while the line stays high is kept.
- R2: Writing with `wr_sel` = 1 stores `wr_data` as the addressed channel's clear code and does not change any output code.
- R3: On a rising edge of `clr_in`, every armed channel's output code becomes its clear code. The new code appears on `code_out` after the third rising clock edge that samples `clr_in` high, and not earlier.
- R4: A channel whose arm bit is 0 keeps its output code across a clear edge.
- R5: After `clr_in` returns low, a cleared channel keeps the clear code until an output code write reaches it.
- R6: When an output code write and a clear edge reach the same armed channel in the same cycle, the clear code is loaded and the write is discarded.
- R7: Synchronous reset sets all output codes, clear codes and arm bits to zero.
- R8: Writing with `wr_sel` = 0 sets the addressed channel's output code on the next clock edge and leaves the other channels unchanged. `wr_sel` = 3 writes nothing.
- R9: Writing with `wr_sel` = 2 sets the channel's arm bit from `wr_data` bit 0. All other data bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_sel | input | 2 | Register selector: 0 output code, 1 clear code, 2 control, 3 none |
| wr_data | input | 16 | Write data |
| clr_in | input | 1 | Asynchronous clear request, active high, edge sensitive |
| code_out | output | 64 | Output codes, channel n in bits [16n+15:16n] |

## Verification
A write is due on `code_out` one clock edge after it is presented, so the bench drives it after a falling edge and samples after the falling edge that follows. A clear needs two synchroniser stages plus the output register, so its result is due three rising edges after `clr_in` is raised. The bench samples after the second of those edges to show that nothing has changed yet, and after the third to see the clear code. The priority test places its write exactly in the cycle of the internal edge pulse, which is the cycle ending at that third edge.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    SEL_CODE    = 2'd0,
    SEL_CLRCODE = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_NONE    = 2'd3
  } occ_sel_e;

  localparam int ARM_BIT = 0;
endpackage

// File: rtl/occ_clr_sync.sv
module occ_clr_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_raw_i,
  output logic pulse_o
);
  logic [SYNC_STAGES-1:0] stage_q;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= 1'b0;
          else     stage_q[0] <= clr_raw_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= 1'b0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= stage_q[SYNC_STAGES-1];
  end

  assign pulse_o = stage_q[SYNC_STAGES-1] & ~prev_q;

  // R1: one pulse per rising edge, never two in a row
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o);
endmodule

// File: rtl/occ_wr_decode.sv
module occ_wr_decode
  import occ_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_ch,
  input  logic [1:0]      wr_sel,
  output logic [NUM_CH-1:0] hit_code,
  output logic [NUM_CH-1:0] hit_clr,
  output logic [NUM_CH-1:0] hit_ctrl
);
  occ_sel_e sel;
  assign sel = occ_sel_e'(wr_sel);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
      logic mine;
      assign mine        = wr_en && (wr_ch == CH_W'(c));
      assign hit_code[c] = mine && (sel == SEL_CODE);
      assign hit_clr[c]  = mine && (sel == SEL_CLRCODE);
      assign hit_ctrl[c] = mine && (sel == SEL_CTRL);
    end
  endgenerate

  // R8: a write reaches at most one channel
  a_r8_one_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_code | hit_clr | hit_ctrl));
  // R8: selector 3 writes nothing
  a_r8_none_sel: assert property (@(posedge clk) disable iff (rst)
    (wr_sel == 2'd3) |-> ((hit_code | hit_clr | hit_ctrl) == '0));
endmodule

// File: rtl/occ_chan.sv
module occ_chan
  import occ_pkg::*;
#(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_pulse,
  input  logic              hit_code,
  input  logic              hit_clr,
  input  logic              hit_ctrl,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] clr_code_q;
  logic              arm_q;
  logic              do_clear;

  assign do_clear = clr_pulse && arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clr_code_q <= '0;
      arm_q      <= 1'b0;
    end else begin
      if (hit_clr)  clr_code_q <= wr_data;
      if (hit_ctrl) arm_q      <= wr_data[ARM_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           code_q <= '0;
    else if (do_clear) code_q <= clr_code_q;
    else if (hit_code) code_q <= wr_data;
  end

  assign code_o = code_q;

  // R3: armed channel takes its clear code on the pulse
  a_r3_clear_load: assert property (@(posedge clk) disable iff (rst)
    (clr_pulse && arm_q) |=> (code_o == $past(clr_code_q)));
  // R4 / R5: no clear and no write leaves the code alone
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!(clr_pulse && arm_q) && !hit_code) |=> $stable(code_o));
  // R6: a write colliding with a clear is discarded
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_pulse && arm_q && hit_code) |=> (code_o == $past(clr_code_q)));
  // R8: a plain write lands next cycle
  a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
    (hit_code && !clr_pulse) |=> (code_o == $past(wr_data)));
endmodule

// File: rtl/out_clear_ctrl.sv
module out_clear_ctrl #(
  parameter int NUM_CH      = 4,
  parameter int CODE_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int OUT_W      = NUM_CH * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [1:0]        wr_sel,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              clr_in,
  output logic [OUT_W-1:0]  code_out
);
  logic              clr_pulse;
  logic [NUM_CH-1:0] hit_code;
  logic [NUM_CH-1:0] hit_clr;
  logic [NUM_CH-1:0] hit_ctrl;

  occ_clr_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .clr_raw_i (clr_in),
    .pulse_o   (clr_pulse)
  );

  occ_wr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_ch    (wr_ch),
    .wr_sel   (wr_sel),
    .hit_code (hit_code),
    .hit_clr  (hit_clr),
    .hit_ctrl (hit_ctrl)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      occ_chan #(.CODE_W(CODE_W)) u_chan (
        .clk       (clk),
        .rst       (rst),
        .clr_pulse (clr_pulse),
        .hit_code  (hit_code[c]),
        .hit_clr   (hit_clr[c]),
        .hit_ctrl  (hit_ctrl[c]),
        .wr_data   (wr_data),
        .code_o    (code_out[c*CODE_W +: CODE_W])
      );
    end
  endgenerate

  // R7: everything is zero the cycle after reset
  a_r7_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (code_out == '0));
endmodule

// File: tb/out_clear_ctrl_bench.sv
module out_clear_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [1:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        clr_in = 1'b0;
  logic [63:0] code_out;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  out_clear_ctrl u_out_clear_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
    .wr_data(wr_data), .clr_in(clr_in), .code_out(code_out)
  );

  // {req[3:0], op[1:0] (0 write, 1 clear), ch, sel, data, expected code_out}
  localparam logic [89:0] VEC [15] = '{
    {4'd8, 2'd0, 2'd0, 2'd0, 16'h1111, 64'h0000_0000_0000_1111}, // R8
    {4'd8, 2'd0, 2'd1, 2'd0, 16'h2222, 64'h0000_0000_2222_1111}, // R8
    {4'd8, 2'd0, 2'd2, 2'd0, 16'h3333, 64'h0000_3333_2222_1111}, // R8
    {4'd8, 2'd0, 2'd3, 2'd0, 16'h4444, 64'h4444_3333_2222_1111}, // R8
    {4'd2, 2'd0, 2'd0, 2'd1, 16'hA0A0, 64'h4444_3333_2222_1111}, // R2
    {4'd2, 2'd0, 2'd2, 2'd1, 16'hC0C0, 64'h4444_3333_2222_1111}, // R2
    {4'd2, 2'd0, 2'd3, 2'd1, 16'hD0D0, 64'h4444_3333_2222_1111}, // R2
    {4'd9, 2'd0, 2'd0, 2'd2, 16'h0001, 64'h4444_3333_2222_1111}, // R9
    {4'd9, 2'd0, 2'd2, 2'd2, 16'hFFFF, 64'h4444_3333_2222_1111}, // R9
    {4'd9, 2'd0, 2'd3, 2'd2, 16'h0000, 64'h4444_3333_2222_1111}, // R9
    {4'd8, 2'd0, 2'd1, 2'd3, 16'h9999, 64'h4444_3333_2222_1111}, // R8
    {4'd3, 2'd1, 2'd0, 2'd0, 16'h0000, 64'h4444_C0C0_2222_A0A0}, // R3, R4
    {4'd5, 2'd0, 2'd0, 2'd0, 16'h5555, 64'h4444_C0C0_2222_5555}, // R5
    {4'd9, 2'd0, 2'd1, 2'd2, 16'h0002, 64'h4444_C0C0_2222_5555}, // R9
    {4'd4, 2'd1, 2'd0, 2'd0, 16'h0000, 64'h4444_C0C0_2222_A0A0}  // R4, R9
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: code_out=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] ch, input logic [1:0] sel, input logic [15:0] d);
    wr_en = 1'b1; wr_ch = ch; wr_sel = sel; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_clear();
    clr_in = 1'b1;
    repeat (3) tick();
    clr_in = 1'b0;
    repeat (3) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: run did not end");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    check("R7 reset state", code_out, 64'h0);

    for (int i = 0; i < 15; i++) begin
      if (VEC[i][85:84] == 2'd1) begin
        clr_in = 1'b1;
        repeat (3) tick();
        check($sformatf("R%0d vector %0d", VEC[i][89:86], i), code_out, VEC[i][63:0]);
        clr_in = 1'b0;
        repeat (3) tick();
      end else begin
        do_write(VEC[i][83:82], VEC[i][81:80], VEC[i][79:64]);
        check($sformatf("R%0d vector %0d", VEC[i][89:86], i), code_out, VEC[i][63:0]);
      end
    end

    // R3 latency: nothing after two edges, clear after the third
    do_write(2'd0, 2'd0, 16'h1234);
    clr_in = 1'b1;
    tick(); tick();
    check("R3 not yet cleared", code_out, 64'h4444_C0C0_2222_1234);
    tick();
    check("R3 cleared on third edge", code_out, 64'h4444_C0C0_2222_A0A0);

    // R1: level held high does not clear again
    do_write(2'd0, 2'd0, 16'h7777);
    repeat (4) tick();
    check("R1 level ignored", code_out, 64'h4444_C0C0_2222_7777);
    clr_in = 1'b0;
    repeat (3) tick();
    check("R1 falling edge ignored", code_out, 64'h4444_C0C0_2222_7777);

    // R6: write in the cycle of the clear pulse
    clr_in = 1'b1;
    tick(); tick();
    do_write(2'd0, 2'd0, 16'h3C3C);
    check("R6 clear beats write", code_out, 64'h4444_C0C0_2222_A0A0);
    clr_in = 1'b0;
    repeat (5) tick();
    check("R5 clear code persists", code_out, 64'h4444_C0C0_2222_A0A0);

    // R7: reset clears arm bits and clear codes
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
    check("R7 reset mid-run", code_out, 64'h0);
    do_write(2'd0, 2'd0, 16'h0F0F);
    do_clear();
    check("R7 arm bit reset", code_out, 64'h0000_0000_0000_0F0F);
    do_write(2'd0, 2'd2, 16'h0001);
    do_clear();
    check("R7 clear code reset", code_out, 64'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule